// File: doc/BRIEF.md
# Single-Error-Correcting Word Memory with Merged Partial Stores

This block is a small word-addressed memory that protects every 32-bit word with seven check bits. Each location holds a 39-bit codeword, and the check bits are always derived from the word that actually ends up in the array. A core issues requests on a single port with request, grant and response-valid signals. Loads return corrected data together with correctable and uncorrectable error flags.

A store that enables all four byte lanes is encoded and written in one cycle. A store that enables fewer lanes first decodes and corrects the resident word. It then substitutes the enabled lanes, re-encodes the whole 32-bit result, and writes data and check bits together. Grant is withdrawn while this is in progress. A build-time option can instead treat every store as a full-word store, which removes the read phase altogether. A fault-injection input flips any one stored codeword bit, so that correction and detection can be exercised from the ports.

Top module: `ecc_rmw_mem`

## Requirements
- R1: After reset, grant is high, response-valid and both error flags are low, and every location reads back as zero with no error flag.
- R2: A load accepted on a clock edge (request and grant high, write enable low) produces response-valid in the following cycle, with the decoded word on the read data output.
- R3: A store with byte enable 4'b1111 writes the whole word in the accepting cycle. Grant stays high, and response-valid appears in the following cycle with both error flags low.
- R4: A store with any other byte enable value drops grant for exactly one cycle after acceptance. Response-valid appears one cycle after that. Afterwards, byte lane n (bits 8n+7 down to 8n) holds the new data if byte enable bit n is set, and its previous value otherwise.
- R5: A load that follows a partial store, with no injected fault in between, reports neither error flag.
- R6: A load of a word with one flipped codeword bit returns the original data and raises only the correctable flag. The stored codeword is not repaired, so a second load raises the same flag again.
- R7: A load of a word with two flipped codeword bits raises only the uncorrectable flag.
- R8: A partial store over a word with one flipped bit merges into the corrected old word. Its response raises the correctable flag, and later loads are clean.
- R9: A partial store over a word with an uncorrectable error still writes the merged word with fresh check bits. Its response raises the uncorrectable flag, and a later load is clean.
- R10: Pulsing the fault-injection input inverts codeword bit inj_bit_i (0 to 38) of location inj_addr_i. Any single such flip is detected as correctable.
- R11: With the full-word-only option set, the byte enable is ignored. Every store writes all 32 bits in one cycle, and grant never drops.
- R12: The two error flags are never high together, and neither is high without response-valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_i | input | 1 | Request |
| we_i | input | 1 | 1 = store, 0 = load |
| addr_i | input | AW | Word address |
| be_i | input | 4 | Byte-lane enables, bit n selects bits 8n+7:8n |
| wdata_i | input | 32 | Store data, already placed in its lanes |
| gnt_o | output | 1 | Request accepted on this edge when high |
| rvalid_o | output | 1 | Response valid |
| rdata_o | output | 32 | Corrected load data (zero for stores) |
| err_corr_o | output | 1 | Single-bit error corrected |
| err_uncorr_o | output | 1 | Uncorrectable error detected |
| inj_en_i | input | 1 | Invert one stored bit this cycle |
| inj_addr_i | input | AW | Location for fault injection |
| inj_bit_i | input | 6 | Codeword bit index for fault injection |

## Verification
The hardest case to reach is a partial store that lands on a word which is already damaged. The ports never produce such a word in normal operation, so the bench first flips one or two stored bits through the injection input. Only then does it issue the narrow store, and it checks the error flag returned for that store. It then reloads the word to confirm that the merged data came from the corrected old lanes and that the new check bits are consistent. For the double fault, the bench flips two check bits only. This keeps the old data lanes intact, so the merged word can still be predicted exactly.

// File: rtl/ecc_rmw_mem.sv
module ecc_rmw_mem #(
  parameter int DEPTH = 16,
  parameter bit FULL_WORD_ONLY = 1'b0,
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_i,
  input  logic          we_i,
  input  logic [AW-1:0] addr_i,
  input  logic [3:0]    be_i,
  input  logic [31:0]   wdata_i,
  output logic          gnt_o,
  output logic          rvalid_o,
  output logic [31:0]   rdata_o,
  output logic          err_corr_o,
  output logic          err_uncorr_o,
  input  logic          inj_en_i,
  input  logic [AW-1:0] inj_addr_i,
  input  logic [5:0]    inj_bit_i
);
  localparam int CW = 39;

  function automatic logic [CW-1:0] enc(input logic [31:0] d);
    logic [CW-1:0] c;
    logic [4:0] k;
    c = '0;
    k = '0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        c[6'(i)] = d[k];
        k = k + 5'd1;
      end
    for (int b = 0; b < 6; b++)
      for (int i = 1; i < CW; i++)
        if (((i >> b) & 1) == 1 && (i & (i - 1)) != 0)
          c[6'd1 << b] = c[6'd1 << b] ^ c[6'(i)];
    c[0] = ^c[CW-1:1];
    return c;
  endfunction

  function automatic logic [33:0] dec(input logic [CW-1:0] c);
    logic [CW-1:0] f;
    logic [5:0] s;
    logic [31:0] d;
    logic [4:0] k;
    logic cor, unc;
    s = '0;
    for (int i = 1; i < CW; i++)
      if (c[6'(i)]) s = s ^ 6'(i);
    f = c;
    cor = 1'b0;
    unc = 1'b0;
    if (^c) begin
      if (s <= 6'd38) begin
        f[s] = ~f[s];
        cor = 1'b1;
      end else unc = 1'b1;
    end else if (s != 6'd0) unc = 1'b1;
    d = '0;
    k = '0;
    for (int i = 1; i < CW; i++)
      if ((i & (i - 1)) != 0) begin
        d[k] = f[6'(i)];
        k = k + 5'd1;
      end
    return {unc, cor, d};
  endfunction

  logic [CW-1:0] mem [DEPTH];
  logic          busy;
  logic [AW-1:0] h_addr;
  logic [3:0]    h_be;
  logic [31:0]   h_wdata;
  logic [3:0]    be_eff;
  logic [AW-1:0] rd_addr;
  logic [33:0]   rd;
  logic [31:0]   merged;

  assign gnt_o   = !busy;
  assign be_eff  = FULL_WORD_ONLY ? 4'hF : be_i;
  assign rd_addr = busy ? h_addr : addr_i;
  assign rd      = dec(mem[rd_addr]);

  always_comb
    for (int n = 0; n < 4; n++)
      merged[8*n +: 8] = h_be[n] ? h_wdata[8*n +: 8] : rd[8*n +: 8];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
      busy         <= 1'b0;
      h_addr       <= '0;
      h_be         <= '0;
      h_wdata      <= '0;
      rvalid_o     <= 1'b0;
      rdata_o      <= '0;
      err_corr_o   <= 1'b0;
      err_uncorr_o <= 1'b0;
    end else begin
      rvalid_o     <= 1'b0;
      err_corr_o   <= 1'b0;
      err_uncorr_o <= 1'b0;
      if (busy) begin
        mem[h_addr]  <= enc(merged);
        busy         <= 1'b0;
        rvalid_o     <= 1'b1;
        rdata_o      <= '0;
        err_corr_o   <= rd[32];
        err_uncorr_o <= rd[33];
      end else if (req_i) begin
        if (!we_i) begin
          rvalid_o     <= 1'b1;
          rdata_o      <= rd[31:0];
          err_corr_o   <= rd[32];
          err_uncorr_o <= rd[33];
        end else if (be_eff == 4'hF) begin
          mem[addr_i] <= enc(wdata_i);
          rvalid_o    <= 1'b1;
          rdata_o     <= '0;
        end else begin
          busy    <= 1'b1;
          h_addr  <= addr_i;
          h_be    <= be_eff;
          h_wdata <= wdata_i;
        end
      end
      if (inj_en_i)
        mem[inj_addr_i][inj_bit_i] <= ~mem[inj_addr_i][inj_bit_i];
    end
  end
endmodule

module ecc_rmw_mem_chk #(
  parameter bit FULL_WORD_ONLY = 1'b0
) (
  input logic       clk,
  input logic       rst_n,
  input logic       req_i,
  input logic       we_i,
  input logic [3:0] be_i,
  input logic       gnt_o,
  input logic       rvalid_o,
  input logic       err_corr_o,
  input logic       err_uncorr_o
);
  logic acc, part;
  assign acc  = req_i && gnt_o;
  assign part = acc && we_i && be_i != 4'hF && !FULL_WORD_ONLY;

  assert_load_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
    acc && !we_i |=> rvalid_o);
  assert_full_store_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    acc && we_i && (be_i == 4'hF || FULL_WORD_ONLY) |=> gnt_o && rvalid_o);
  assert_partial_stall_R4: assert property (@(posedge clk) disable iff (!rst_n)
    part |=> !gnt_o && !rvalid_o);
  assert_partial_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
    part |=> ##1 (gnt_o && rvalid_o));
  assert_never_stall_R11: assert property (@(posedge clk) disable iff (!rst_n)
    FULL_WORD_ONLY && acc |=> gnt_o);
  assert_flags_exclusive_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(err_corr_o && err_uncorr_o));
  assert_flags_need_valid_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (err_corr_o || err_uncorr_o) |-> rvalid_o);
endmodule

bind ecc_rmw_mem ecc_rmw_mem_chk #(.FULL_WORD_ONLY(FULL_WORD_ONLY)) u_chk (
  .clk(clk), .rst_n(rst_n), .req_i(req_i), .we_i(we_i), .be_i(be_i),
  .gnt_o(gnt_o), .rvalid_o(rvalid_o), .err_corr_o(err_corr_o),
  .err_uncorr_o(err_uncorr_o)
);

// File: tb/ecc_rmw_mem_bench.sv
`timescale 1ns/1ps
module ecc_rmw_mem_bench;
  localparam int DEPTH = 16;
  localparam int AW = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] req = '0;
  logic [1:0] inj = '0;
  logic we = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [3:0] be = '0;
  logic [31:0] wdata = '0;
  logic [AW-1:0] inj_addr = '0;
  logic [5:0] inj_bit = '0;
  logic gnt [2];
  logic rv [2];
  logic cor [2];
  logic unc [2];
  logic [31:0] rdat [2];
  logic [31:0] mdl [2][DEPTH];
  int checks = 0;
  int failures = 0;

  always #2 clk = ~clk;

  ecc_rmw_mem #(.DEPTH(DEPTH), .FULL_WORD_ONLY(1'b0)) u_ecc_rmw_mem (
    .clk(clk), .rst_n(rst_n), .req_i(req[0]), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .gnt_o(gnt[0]), .rvalid_o(rv[0]),
    .rdata_o(rdat[0]), .err_corr_o(cor[0]), .err_uncorr_o(unc[0]),
    .inj_en_i(inj[0]), .inj_addr_i(inj_addr), .inj_bit_i(inj_bit));

  ecc_rmw_mem #(.DEPTH(DEPTH), .FULL_WORD_ONLY(1'b1)) u_ecc_rmw_mem_fw (
    .clk(clk), .rst_n(rst_n), .req_i(req[1]), .we_i(we), .addr_i(addr),
    .be_i(be), .wdata_i(wdata), .gnt_o(gnt[1]), .rvalid_o(rv[1]),
    .rdata_o(rdat[1]), .err_corr_o(cor[1]), .err_uncorr_o(unc[1]),
    .inj_en_i(inj[1]), .inj_addr_i(inj_addr), .inj_bit_i(inj_bit));

  task automatic chk(input string r, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s act=%h exp=%h", r, act, exp);
    end
  endtask

  task automatic load(input int s, input int a, input string r,
                      input logic [31:0] ed, input logic ec, input logic eu);
    @(negedge clk);
    chk({r, " grant before load"}, {31'd0, gnt[s]}, 32'd1);
    addr = AW'(a); we = 1'b0; req[s] = 1'b1;
    @(negedge clk);
    req[s] = 1'b0;
    chk({r, " R2 load valid"}, {31'd0, rv[s]}, 32'd1);
    chk({r, " load data"}, rdat[s], ed);
    chk({r, " load flags"}, {30'd0, unc[s], cor[s]}, {30'd0, eu, ec});
    chk({r, " R12 exclusive"}, {31'd0, cor[s] & unc[s]}, 32'd0);
  endtask

  task automatic store(input int s, input int a, input logic [3:0] b,
                       input logic [31:0] d, input string r,
                       input logic ec, input logic eu);
    logic [3:0] eb;
    eb = (s == 1) ? 4'hF : b;
    @(negedge clk);
    addr = AW'(a); we = 1'b1; be = b; wdata = d; req[s] = 1'b1;
    @(negedge clk);
    req[s] = 1'b0;
    if (eb != 4'hF) begin
      chk({r, " R4 grant low"}, {31'd0, gnt[s]}, 32'd0);
      chk({r, " R4 no early valid"}, {29'd0, rv[s], cor[s], unc[s]}, 32'd0);
      @(negedge clk);
    end
    chk({r, " R3/R4 store response"}, {30'd0, gnt[s], rv[s]}, 32'd3);
    chk({r, " store flags"}, {30'd0, unc[s], cor[s]}, {30'd0, eu, ec});
    for (int n = 0; n < 4; n++)
      if (eb[n]) mdl[s][a][8*n +: 8] = d[8*n +: 8];
  endtask

  task automatic flip(input int s, input int a, input int bt);
    @(negedge clk);
    inj_addr = AW'(a); inj_bit = 6'(bt); inj[s] = 1'b1;
    @(negedge clk);
    inj[s] = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; failures++;
    $display("FAIL watchdog expired act=running exp=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    for (int s = 0; s < 2; s++)
      for (int a = 0; a < DEPTH; a++) mdl[s][a] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 reset outputs", {28'd0, gnt[0], rv[0], cor[0], unc[0]}, 32'h8);
    for (int a = 0; a < DEPTH; a++) load(0, a, "R1 reset word", 32'd0, 1'b0, 1'b0);

    for (int a = 0; a < DEPTH; a++)
      store(0, a, 4'hF, 32'hA5C3_0000 ^ (32'h0101_0101 * a), "R3 full", 1'b0, 1'b0);
    for (int a = 0; a < DEPTH; a++) load(0, a, "R2 R3 readback", mdl[0][a], 1'b0, 1'b0);

    for (int a = 0; a < DEPTH; a++) begin
      store(0, a, 4'(a), 32'h5A5A_5A5A + 32'(a) * 32'h1357_9BDF, "R4 sweep", 1'b0, 1'b0);
      load(0, a, "R4 R5 merged", mdl[0][a], 1'b0, 1'b0);
    end
    for (int a = 0; a < DEPTH; a++) begin
      store(0, a, 4'(15 - a), ~(32'(a) * 32'h0F1E_2D3C), "R4 sweep2", 1'b0, 1'b0);
      load(0, a, "R5 merged2", mdl[0][a], 1'b0, 1'b0);
    end

    for (int bt = 0; bt < 39; bt++) begin
      flip(0, bt % DEPTH, bt);
      load(0, bt % DEPTH, "R6 R10 single", mdl[0][bt % DEPTH], 1'b1, 1'b0);
      load(0, bt % DEPTH, "R6 still stored", mdl[0][bt % DEPTH], 1'b1, 1'b0);
      store(0, bt % DEPTH, 4'hF, mdl[0][bt % DEPTH], "R3 repair", 1'b0, 1'b0);
    end

    for (int k = 0; k < 8; k++) begin
      flip(0, k, k * 3);
      flip(0, k, k * 3 + 7);
      @(negedge clk);
      checks++;
      addr = AW'(k); we = 1'b0; req[0] = 1'b1;
      @(negedge clk);
      req[0] = 1'b0;
      if (!(rv[0] && unc[0] && !cor[0])) begin
        failures++;
        $display("FAIL R7 double act=%b%b%b exp=110", rv[0], unc[0], cor[0]);
      end
      store(0, k, 4'hF, mdl[0][k], "R3 repair2", 1'b0, 1'b0);
    end

    flip(0, 7, 10);
    store(0, 7, 4'b0011, 32'h1234_BEEF, "R8 rmw single", 1'b1, 1'b0);
    load(0, 7, "R8 clean after", mdl[0][7], 1'b0, 1'b0);

    flip(0, 9, 0);
    flip(0, 9, 1);
    store(0, 9, 4'b1100, 32'hCAFE_0000, "R9 rmw double", 1'b0, 1'b1);
    load(0, 9, "R9 clean after", mdl[0][9], 1'b0, 1'b0);

    for (int a = 0; a < DEPTH; a++) begin
      store(1, a, 4'(a), 32'h600D_F00D ^ (32'(a) << 3), "R11 forced full", 1'b0, 1'b0);
      load(1, a, "R11 whole word", mdl[1][a], 1'b0, 1'b0);
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule